// File: doc/BRIEF.md
# Filtered External Interrupt Detector

This block turns one asynchronous external pin into an interrupt request flag. The pin first passes through a two-flop synchronizer. It can then go through an optional noise filter that accepts a new level only after three agreeing samples taken on a selectable sampling strobe. A mode field selects the transition that counts: rising, falling, either, or none.

Without the filter, a detected transition raises the request flag at once. It can instead be held until the next tick from a selectable count source. With the filter on, requests always line up with the sampling strobe. The flag stays set until software clears it.

A raw readback output always shows the synchronized pin level before any filtering. The tick and strobe generators, the timer counter and interrupt prioritisation lie outside this block.

Top module: `ext_irq_detect`

## Requirements
- R1: While `rst` is high and just after it, `irq_req` and `pin_raw` are 0, and the internal accepted level is low.
- R2: `pin_raw` shows the `pin_in` level two clock edges after it is driven, whatever the value of `filt_sel`.
- R3: With `filt_sel`=00 the accepted level follows the synchronized pin. With `edge_sel`=00 (rising) and `immediate`=1, a rise sets `irq_req` one clock after `pin_raw` goes high, and a fall sets nothing.
- R4: `edge_sel`=01 requests on falling transitions only. `edge_sel`=10 requests on both rising and falling transitions.
- R5: `edge_sel`=11 is reserved and never sets `irq_req`.
- R6: `irq_req` stays set until `irq_clr`=1 is seen at a clock edge. A new request arriving in the same cycle as the clear wins, so the flag stays set.
- R7: With `filt_sel`=00, `immediate`=0 and `cnt_en`=1, a detected transition sets `irq_req` only at a later clock edge where the selected count tick is high. A tick in the same cycle as the detection does not count.
- R8: `src_sel` picks `src_ticks[src_sel]`: 00 is the divide-by-1 tick, 01 divide-by-8, 10 divide-by-32 and 11 the alternate fast tick. Ticks on the other inputs have no effect.
- R9: A request waiting for a count tick is cancelled when `cnt_en` is 0, or when the timing mode stops being deferred. A transition seen while `cnt_en`=0 in deferred mode is dropped.
- R10: With `filt_sel` at 01, 10 or 11, sampling uses `samp_stb[0]`, `[1]` or `[2]` in that order. The accepted level changes only on a strobe whose sample matches the samples of the two previous strobes, and a qualifying request is set at that same edge.
- R11: With the filter on, a new pin level seen on fewer than three consecutive strobes leaves the accepted level unchanged and raises no request.
- R12: With the filter on, requests do not wait for a count tick, whatever `immediate` holds, and strobes on unselected inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous external pin |
| samp_stb | input | NUM_STROBES (3) | Sampling strobes for the filter |
| src_ticks | input | NUM_SRC (4) | Count-source ticks: div1, div8, div32, fast |
| cnt_en | input | 1 | Count enable; 0 cancels deferred requests |
| edge_sel | input | 2 | 00 rise, 01 fall, 10 both, 11 reserved |
| src_sel | input | 2 | Count-source tick select |
| immediate | input | 1 | 1: request at once; 0: wait for count tick |
| filt_sel | input | 2 | 00 no filter; 01/10/11 filter on strobe 0/1/2 |
| irq_clr | input | 1 | Clear pulse for the request flag |
| pin_raw | output | 1 | Synchronized pin level before filtering |
| irq_req | output | 1 | Interrupt request flag |

## Verification
The hardest cases to reach are the ones where two events fall in one clock cycle. One is a request arriving in the same cycle as a software clear. The other is a count tick coinciding with the cycle in which a transition is first detected. The bench counts the two synchronizer edges from a pin change driven at the falling clock edge, so it knows exactly which cycle holds the detection. It raises `irq_clr` or the selected tick in that cycle. For the filter, strobes are pulsed one at a time, so the bench can see the flag still low after two agreeing samples and set after the third.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_mode_t;
endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= '0;
    else     ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/eid_level.sv
module eid_level #(
  parameter int NUM_STROBES = 3,
  parameter int DEPTH       = 3,
  localparam int SELW       = $clog2(NUM_STROBES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp,
  input  logic [SELW-1:0]        filt_sel,
  input  logic [NUM_STROBES-1:0] strobes,
  output logic                   rise,
  output logic                   fall,
  output logic                   filt_on
);
  logic             lvl;
  logic [DEPTH-2:0] hist;
  logic             stb;
  logic             agree;
  logic             take;

  always_comb begin
    stb = 1'b0;
    for (int i = 0; i < NUM_STROBES; i++)
      if (filt_sel == SELW'(i + 1)) stb = strobes[i];
  end

  always_comb begin
    agree = 1'b1;
    for (int i = 0; i < DEPTH - 1; i++)
      if (hist[i] != smp) agree = 1'b0;
  end

  assign filt_on = (filt_sel != '0);
  assign take    = filt_on ? (stb && agree) : 1'b1;
  assign rise    = take &&  smp && !lvl;
  assign fall    = take && !smp &&  lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl  <= 1'b0;
      hist <= '0;
    end else begin
      if (filt_on && stb) hist <= {hist[DEPTH-3:0], smp};
      if (take)           lvl  <= smp;
    end
  end
endmodule

// File: rtl/eid_request.sv
module eid_request
  import ext_irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int SRCW   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rise,
  input  logic               fall,
  input  logic               filt_on,
  input  edge_mode_t         edge_mode,
  input  logic               immediate,
  input  logic               cnt_en,
  input  logic [SRCW-1:0]    src_sel,
  input  logic [NUM_SRC-1:0] src_ticks,
  input  logic               irq_clr,
  output logic               irq
);
  logic hit;
  logic deferred_mode;
  logic tick;
  logic direct;
  logic defer;
  logic fire;
  logic pend;

  always_comb begin
    unique case (edge_mode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  assign deferred_mode = !filt_on && !immediate && cnt_en;
  assign tick          = src_ticks[src_sel];
  assign direct        = hit && (filt_on || immediate);
  assign defer         = hit && deferred_mode;
  assign fire          = pend && tick && deferred_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      pend <= deferred_mode && (defer || (pend && !tick));
      irq  <= direct || fire || (irq && !irq_clr);
    end
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int NUM_STROBES = 3,
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 3,
  localparam int FSW        = $clog2(NUM_STROBES + 1),
  localparam int SRCW       = $clog2(NUM_SRC)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pin_in,
  input  logic [NUM_STROBES-1:0] samp_stb,
  input  logic [NUM_SRC-1:0]     src_ticks,
  input  logic                   cnt_en,
  input  logic [1:0]             edge_sel,
  input  logic [SRCW-1:0]        src_sel,
  input  logic                   immediate,
  input  logic [FSW-1:0]         filt_sel,
  input  logic                   irq_clr,
  output logic                   pin_raw,
  output logic                   irq_req
);
  logic rise;
  logic fall;
  logic filt_on;

  eid_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_raw)
  );

  eid_level #(.NUM_STROBES(NUM_STROBES), .DEPTH(FILT_DEPTH)) u_level (
    .clk(clk), .rst(rst), .smp(pin_raw), .filt_sel(filt_sel),
    .strobes(samp_stb), .rise(rise), .fall(fall), .filt_on(filt_on)
  );

  eid_request #(.NUM_SRC(NUM_SRC)) u_req (
    .clk(clk), .rst(rst), .rise(rise), .fall(fall), .filt_on(filt_on),
    .edge_mode(edge_mode_t'(edge_sel)), .immediate(immediate),
    .cnt_en(cnt_en), .src_sel(src_sel), .src_ticks(src_ticks),
    .irq_clr(irq_clr), .irq(irq_req)
  );
endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
  parameter int NUM_STROBES = 3,
  parameter int NUM_SRC     = 4,
  localparam int FSW        = $clog2(NUM_STROBES + 1),
  localparam int SRCW       = $clog2(NUM_SRC)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_STROBES-1:0] samp_stb,
  input logic [NUM_SRC-1:0]     src_ticks,
  input logic                   cnt_en,
  input logic [1:0]             edge_sel,
  input logic [SRCW-1:0]        src_sel,
  input logic                   immediate,
  input logic [FSW-1:0]         filt_sel,
  input logic                   irq_clr,
  input logic                   irq_req
);
  logic sel_stb;
  always_comb begin
    sel_stb = 1'b0;
    for (int i = 0; i < NUM_STROBES; i++)
      if (filt_sel == FSW'(i + 1)) sel_stb = samp_stb[i];
  end

  assert_rsvd_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (edge_sel == 2'b11 && !irq_req) |=> !irq_req);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_clr) |=> irq_req);

  assert_defer_tick_R7: assert property (@(posedge clk) disable iff (rst)
    (filt_sel == '0 && !immediate && !irq_req && !src_ticks[src_sel]) |=> !irq_req);

  assert_cancel_R9: assert property (@(posedge clk) disable iff (rst)
    (filt_sel == '0 && !immediate && !cnt_en && !irq_req) |=> !irq_req);

  assert_strobe_align_R10: assert property (@(posedge clk) disable iff (rst)
    (filt_sel != '0 && !sel_stb && !irq_req) |=> !irq_req);
endmodule

bind ext_irq_detect ext_irq_detect_chk #(
  .NUM_STROBES(NUM_STROBES), .NUM_SRC(NUM_SRC)
) u_chk (
  .clk(clk), .rst(rst), .samp_stb(samp_stb), .src_ticks(src_ticks),
  .cnt_en(cnt_en), .edge_sel(edge_sel), .src_sel(src_sel),
  .immediate(immediate), .filt_sel(filt_sel), .irq_clr(irq_clr),
  .irq_req(irq_req)
);

// File: tb/ext_irq_detect_test.sv
module ext_irq_detect_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_in = 1'b0;
  logic [2:0] samp_stb = '0;
  logic [3:0] src_ticks = '0;
  logic       cnt_en = 1'b1;
  logic [1:0] edge_sel = 2'b00;
  logic [1:0] src_sel = 2'b00;
  logic       immediate = 1'b1;
  logic [1:0] filt_sel = 2'b00;
  logic       irq_clr = 1'b0;
  logic       pin_raw;
  logic       irq_req;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  ext_irq_detect uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .samp_stb(samp_stb),
    .src_ticks(src_ticks), .cnt_en(cnt_en), .edge_sel(edge_sel),
    .src_sel(src_sel), .immediate(immediate), .filt_sel(filt_sel),
    .irq_clr(irq_clr), .pin_raw(pin_raw), .irq_req(irq_req)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pin_in = 1'b0; samp_stb = '0; src_ticks = '0;
    cnt_en = 1'b1; edge_sel = 2'b00; src_sel = 2'b00; immediate = 1'b1;
    filt_sel = 2'b00; irq_clr = 1'b0;
    cyc(2);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic strobe(input int idx);
    samp_stb[idx] = 1'b1; cyc(1); samp_stb[idx] = 1'b0; cyc(1);
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 irq after reset", irq_req, 1'b0);
    check("R1 pin_raw after reset", pin_raw, 1'b0);
  endtask

  task automatic t_readback();
    do_reset();
    pin_in = 1'b1; cyc(1);
    check("R2 pin_raw after one edge", pin_raw, 1'b0);
    cyc(1);
    check("R2 pin_raw after two edges", pin_raw, 1'b1);
    filt_sel = 2'b10;
    pin_in = 1'b0; cyc(1);
    check("R2 filtered pin_raw one edge", pin_raw, 1'b1);
    cyc(1);
    check("R2 filtered pin_raw two edges", pin_raw, 1'b0);
  endtask

  task automatic t_rise();
    do_reset();
    pin_in = 1'b1; cyc(2);
    check("R3 no irq yet", irq_req, 1'b0);
    cyc(1);
    check("R3 rise sets irq", irq_req, 1'b1);
    clear_irq();
    pin_in = 1'b0; cyc(4);
    check("R3 fall ignored in rise mode", irq_req, 1'b0);
  endtask

  task automatic t_fall_both();
    do_reset();
    edge_sel = 2'b01;
    pin_in = 1'b1; cyc(4);
    check("R4 rise ignored in fall mode", irq_req, 1'b0);
    pin_in = 1'b0; cyc(3);
    check("R4 fall sets irq", irq_req, 1'b1);
    clear_irq();
    edge_sel = 2'b10;
    pin_in = 1'b1; cyc(3);
    check("R4 both: rise sets", irq_req, 1'b1);
    clear_irq();
    pin_in = 1'b0; cyc(3);
    check("R4 both: fall sets", irq_req, 1'b1);
  endtask

  task automatic t_rsvd();
    do_reset();
    edge_sel = 2'b11;
    pin_in = 1'b1; cyc(4);
    check("R5 reserved rise", irq_req, 1'b0);
    pin_in = 1'b0; cyc(4);
    check("R5 reserved fall", irq_req, 1'b0);
  endtask

  task automatic t_clear();
    do_reset();
    edge_sel = 2'b10;
    pin_in = 1'b1; cyc(3);
    cyc(3);
    check("R6 flag holds", irq_req, 1'b1);
    clear_irq();
    check("R6 clear drops flag", irq_req, 1'b0);
    cyc(1);
    pin_in = 1'b1; cyc(1);
    pin_in = 1'b0; cyc(3);
    check("R6 set again", irq_req, 1'b1);
    pin_in = 1'b1; cyc(2);
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    check("R6 set wins over clear", irq_req, 1'b1);
  endtask

  task automatic t_defer();
    do_reset();
    immediate = 1'b0; src_sel = 2'b10;
    pin_in = 1'b1; cyc(2);
    src_ticks[2] = 1'b1; cyc(1); src_ticks[2] = 1'b0;
    check("R7 same-cycle tick ignored", irq_req, 1'b0);
    cyc(2);
    check("R7 waits for tick", irq_req, 1'b0);
    src_ticks[0] = 1'b1; src_ticks[3] = 1'b1; cyc(1); src_ticks = '0;
    check("R8 unselected ticks ignored", irq_req, 1'b0);
    src_ticks[2] = 1'b1; cyc(1); src_ticks[2] = 1'b0;
    check("R7 R8 selected tick sets irq", irq_req, 1'b1);
  endtask

  task automatic t_cancel();
    do_reset();
    immediate = 1'b0;
    pin_in = 1'b1; cyc(3);
    cnt_en = 1'b0; cyc(1); cnt_en = 1'b1;
    src_ticks[0] = 1'b1; cyc(1); src_ticks[0] = 1'b0;
    check("R9 pending cancelled", irq_req, 1'b0);
    pin_in = 1'b0; cyc(3);
    cnt_en = 1'b0; pin_in = 1'b1; cyc(4); cnt_en = 1'b1;
    src_ticks[0] = 1'b1; cyc(1); src_ticks[0] = 1'b0;
    check("R9 event while disabled dropped", irq_req, 1'b0);
  endtask

  task automatic t_filter();
    do_reset();
    filt_sel = 2'b01; immediate = 1'b0;
    pin_in = 1'b1; cyc(3);
    strobe(0);
    strobe(1);
    strobe(2);
    strobe(0);
    check("R10 two samples not enough", irq_req, 1'b0);
    samp_stb[0] = 1'b1; cyc(1); samp_stb[0] = 1'b0;
    check("R10 R12 third sample sets irq without tick", irq_req, 1'b1);
  endtask

  task automatic t_glitch();
    do_reset();
    filt_sel = 2'b11; edge_sel = 2'b10;
    pin_in = 1'b1; cyc(3);
    strobe(2); strobe(2);
    pin_in = 1'b0; cyc(3);
    strobe(2); strobe(2); strobe(2);
    check("R11 short pulse rejected", irq_req, 1'b0);
    pin_in = 1'b1; cyc(3);
    strobe(2); strobe(2); strobe(2);
    check("R11 steady level accepted", irq_req, 1'b1);
  endtask

  initial begin
    #(20 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_readback();
    t_rise();
    t_fall_both();
    t_rsvd();
    t_clear();
    t_defer();
    t_cancel();
    t_filter();
    t_glitch();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule